// File: doc/BRIEF.md
# Flash Program/Erase Status Generator

This block produces the status byte that a parallel NOR flash places on its data bus while its embedded program/erase engine is working. It sits between the array read path and the data pins. When nothing is running, a read returns the array data unchanged. While an operation runs, or while a failure is pending, a read returns a status byte instead of array data. The status byte carries a toggle bit that inverts on each read access, an error bit and an erase-timer bit.

The block also owns two interval timers. The first is the block-erase accumulation window. It opens when an erase command is accepted and restarts on each further erase command. When it closes, the block pulses a start request to the engine. The second is a fake busy period, shown when every block selected for erase is protected. Both lengths are given in microseconds and converted to clock cycles from the clock frequency parameter.

A program command aimed at a protected block never raises the engine's busy signal, so reads keep returning array data. After an operation completes, the array supplies the programmed value or the erased ones through the pass-through path.

Top module: `flash_status_gen`

## Requirements
- R1: When no read access is active, `dq_oe_o` is 0 and `dq_o` is 0. A read access is active while `ce_ni` and `oe_ni` are both low.
- R2: During a read access with no status condition pending, `dq_o` equals `array_data_i` and `dq_oe_o` is 1.
- R3: During status mode, bit 6 of `dq_o` is the toggle bit. It holds steady within one read access and inverts after each access ends. An access ends when `ce_ni` rises, or when `oe_ni` rises with `ce_ni` held low.
- R4: Bit 5 is the error bit. It reads 0 during a successful operation. A `ctrl_fail_i` pulse sets it to 1 from the next cycle. Status mode then persists, even after busy drops, until a `reset_cmd_i` pulse returns reads to array data from the next cycle.
- R5: An `erase_cmd_i` pulse with `erase_all_prot_i` low opens the window for WIN_US*CLK_MHZ cycles, counted from the next cycle. During the window, status mode is active and bit 3 reads 0. Each further erase command restarts the window. On the cycle after the window's last cycle, `erase_go_o` is 1 for exactly one cycle.
- R6: An `erase_cmd_i` pulse with `erase_all_prot_i` high, accepted while no window is open, gives status mode with bit 3 = 1 and bit 5 = 0 for PROT_US*CLK_MHZ cycles. Reads then return array data.
- R7: In status mode, bits 7, 4, 2, 1 and 0 of `dq_o` read 0.
- R8: While `ctrl_busy_i` is high outside the window, bit 3 equals `ctrl_erase_i`. `ctrl_erase_i` is 1 for an erase and 0 for a program.
- R9: After reset the toggle bit is 0, the error bit is clear and no window or fake busy period is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| array_data_i | input | DATA_W | Data read from the array |
| ctrl_busy_i | input | 1 | Embedded engine is running an operation |
| ctrl_erase_i | input | 1 | Running operation is an erase (1) or a program (0) |
| ctrl_fail_i | input | 1 | One-cycle pulse: the operation failed |
| reset_cmd_i | input | 1 | One-cycle pulse: Reset command decoded |
| erase_cmd_i | input | 1 | One-cycle pulse: a block erase command was accepted |
| erase_all_prot_i | input | 1 | Every block selected by this erase is protected |
| erase_go_o | output | 1 | One-cycle pulse: the window has expired and the engine may start the erase |
| dq_o | output | DATA_W | Data bus output value |
| dq_oe_o | output | 1 | Data bus output enable |

## Verification
The data path is combinational. A status byte or array value is therefore due in the same cycle as the strobes and condition that select it. Pulses on `ctrl_fail_i`, `reset_cmd_i` and `erase_cmd_i` take effect one edge later. The toggle bit flips on the first edge after an access ends. The bench drives every input on the falling clock edge and samples on the next falling edge, so each registered effect has exactly one rising edge to occur. The window and fake busy checks count falling edges from the end of the command pulse. Each check samples both the last cycle inside the interval and the first cycle after it, so an off-by-one length or a missed restart shows up.

// File: rtl/flash_stat_pkg.sv
`timescale 1ns/1ps
package flash_stat_pkg;
  localparam int unsigned TOG_POS = 6;
  localparam int unsigned ERR_POS = 5;
  localparam int unsigned TMR_POS = 3;

  typedef struct packed {
    logic tog;
    logic err;
    logic tmr;
  } stat_bits_t;
endpackage

// File: rtl/fs_interval.sv
`timescale 1ns/1ps
module fs_interval #(
  parameter int unsigned LEN = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic active_o,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(LEN + 1);
  localparam logic [CNT_W-1:0] LEN_C = CNT_W'(LEN);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= (cnt_q == ONE_C) && !load_i;
      if (load_i)             cnt_q <= LEN_C;
      else if (cnt_q != '0)   cnt_q <= cnt_q - ONE_C;
    end
  end

  assign active_o = (cnt_q != '0);
  assign done_o   = done_q;

  // R5
  load_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == LEN_C));

  // R5
  done_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(cnt_q) == ONE_C && cnt_q == '0));
endmodule

// File: rtl/fs_read_strobe.sv
`timescale 1ns/1ps
module fs_read_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic oe_ni,
  input  logic adv_en_i,
  output logic read_o,
  output logic tog_o
);
  logic read_w;
  logic read_q;
  logic tog_q;

  assign read_w = !ce_ni && !oe_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      read_q <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      read_q <= read_w;
      // access ended: flip for the next read
      if (read_q && !read_w && adv_en_i) tog_q <= !tog_q;
    end
  end

  assign read_o = read_w;
  assign tog_o  = tog_q;

  // R3
  tog_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_w |=> (!read_w || $stable(tog_q)));
endmodule

// File: rtl/fs_err_latch.sv
`timescale 1ns/1ps
module fs_err_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic err_o
);
  logic err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     err_q <= 1'b0;
    else if (set_i)  err_q <= 1'b1;
    else if (clr_i)  err_q <= 1'b0;
  end

  assign err_o = err_q;

  // R4
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !clr_i) |=> err_q);

  // R4
  err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !err_q);
endmodule

// File: rtl/fs_status_mux.sv
`timescale 1ns/1ps
module fs_status_mux #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      read_i,
  input  logic                      stat_mode_i,
  input  flash_stat_pkg::stat_bits_t bits_i,
  input  logic [DATA_W-1:0]         array_i,
  output logic [DATA_W-1:0]         dq_o,
  output logic                      dq_oe_o
);
  import flash_stat_pkg::*;

  logic [DATA_W-1:0] stat_w;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b == TOG_POS) begin : g_tog
      assign stat_w[b] = bits_i.tog;
    end else if (b == ERR_POS) begin : g_err
      assign stat_w[b] = bits_i.err;
    end else if (b == TMR_POS) begin : g_tmr
      assign stat_w[b] = bits_i.tmr;
    end else begin : g_zero
      assign stat_w[b] = 1'b0;
    end
  end

  always_comb begin
    dq_o = '0;
    if (read_i) dq_o = stat_mode_i ? stat_w : array_i;
  end
  assign dq_oe_o = read_i;

  localparam logic [DATA_W-1:0] KEEP_M =
    (DATA_W'(1) << TOG_POS) | (DATA_W'(1) << ERR_POS) | (DATA_W'(1) << TMR_POS);

  // R7
  spare_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_i && stat_mode_i) |-> ((dq_o & ~KEEP_M) == '0));

  // R1
  idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dq_oe_o |-> (dq_o == '0));
endmodule

// File: rtl/flash_status_gen.sv
`timescale 1ns/1ps
module flash_status_gen #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CLK_MHZ = 200,
  parameter int unsigned WIN_US  = 100,
  parameter int unsigned PROT_US = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic [DATA_W-1:0] array_data_i,
  input  logic              ctrl_busy_i,
  input  logic              ctrl_erase_i,
  input  logic              ctrl_fail_i,
  input  logic              reset_cmd_i,
  input  logic              erase_cmd_i,
  input  logic              erase_all_prot_i,
  output logic              erase_go_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  import flash_stat_pkg::*;

  localparam int unsigned WIN_CYC  = WIN_US * CLK_MHZ;
  localparam int unsigned PROT_CYC = PROT_US * CLK_MHZ;

  logic win_act, win_done, prot_act, prot_done;
  logic win_load, prot_load;
  logic err, tog, read, stat_mode;
  stat_bits_t bits;

  assign win_load  = erase_cmd_i && (!erase_all_prot_i || win_act);
  assign prot_load = erase_cmd_i && erase_all_prot_i && !win_act;

  fs_interval #(.LEN(WIN_CYC)) u_win (
    .clk_i, .rst_ni, .load_i(win_load), .active_o(win_act), .done_o(win_done)
  );

  fs_interval #(.LEN(PROT_CYC)) u_prot (
    .clk_i, .rst_ni, .load_i(prot_load), .active_o(prot_act), .done_o(prot_done)
  );

  fs_err_latch u_err (
    .clk_i, .rst_ni, .set_i(ctrl_fail_i), .clr_i(reset_cmd_i), .err_o(err)
  );

  assign stat_mode = ctrl_busy_i || win_act || prot_act || err;

  fs_read_strobe u_rd (
    .clk_i, .rst_ni, .ce_ni, .oe_ni, .adv_en_i(stat_mode), .read_o(read), .tog_o(tog)
  );

  always_comb begin
    bits.tog = tog;
    bits.err = err;
    bits.tmr = win_act ? 1'b0 : (prot_act || (ctrl_busy_i && ctrl_erase_i));
  end

  fs_status_mux #(.DATA_W(DATA_W)) u_mux (
    .clk_i, .rst_ni, .read_i(read), .stat_mode_i(stat_mode), .bits_i(bits),
    .array_i(array_data_i), .dq_o, .dq_oe_o
  );

  assign erase_go_o = win_done;

  // R5
  win_tmr_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_act && read) |-> !dq_o[TMR_POS]);

  // R6
  prot_no_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_done |-> !erase_go_o);
endmodule

// File: tb/flash_status_gen_bench.sv
`timescale 1ns/1ps
module flash_status_gen_bench;
  localparam int unsigned DW   = 8;
  localparam int unsigned MHZ  = 1;
  localparam int unsigned WUS  = 40;
  localparam int unsigned PUS  = 60;
  localparam int unsigned WCYC = WUS * MHZ;
  localparam int unsigned PCYC = PUS * MHZ;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1;
  logic [DW-1:0] arr = 8'h00;
  logic busy = 1'b0, ers = 1'b0, fail = 1'b0, rcmd = 1'b0, ecmd = 1'b0, eprot = 1'b0;
  logic go;
  logic [DW-1:0] dq;
  logic dq_oe;

  int errors = 0;
  int checks = 0;
  bit fin = 1'b0;
  logic exp_tog = 1'b0;

  always #2.5 clk = ~clk;

  flash_status_gen #(.DATA_W(DW), .CLK_MHZ(MHZ), .WIN_US(WUS), .PROT_US(PUS)) u_flash_status_gen (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .array_data_i(arr),
    .ctrl_busy_i(busy), .ctrl_erase_i(ers), .ctrl_fail_i(fail), .reset_cmd_i(rcmd),
    .erase_cmd_i(ecmd), .erase_all_prot_i(eprot), .erase_go_o(go), .dq_o(dq), .dq_oe_o(dq_oe)
  );

  function automatic logic [7:0] sb(input logic t, input logic e, input logic m);
    return {1'b0, t, e, 1'b0, m, 3'b000};
  endfunction

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // one access; oe_only keeps ce low and strobes oe
  task automatic rd(input logic [DW-1:0] exp, input string tag, input bit stat, input bit oe_only);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    chk(dq, exp, tag);
    chk({7'd0, dq_oe}, 8'd1, tag);
    oe_n = 1'b1;
    if (!oe_only) ce_n = 1'b1;
    @(negedge clk);
    if (stat) exp_tog = ~exp_tog;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(dq, 8'h00, "R1 idle bus value");
    chk({7'd0, dq_oe}, 8'd0, "R1 idle bus enable");
    arr = 8'h3C;
    rd(8'h3C, "R2/R9 pass-through after reset", 1'b0, 1'b0);
    arr = 8'hC3;
    rd(8'hC3, "R2 pass-through second pattern", 1'b0, 1'b0);
  endtask

  task automatic t_toggle;
    arr = 8'hFF; busy = 1'b1; ers = 1'b0;
    rd(sb(1'b0, 1'b0, 1'b0), "R9 first toggle value 0", 1'b1, 1'b0);
    rd(sb(exp_tog, 1'b0, 1'b0), "R3 toggle inverted by ce", 1'b1, 1'b1);
    rd(sb(exp_tog, 1'b0, 1'b0), "R3 toggle inverted by oe only", 1'b1, 1'b0);
    rd(sb(exp_tog, 1'b0, 1'b0), "R7 spare bits zero with array FF", 1'b1, 1'b0);
    ce_n = 1'b1;
    busy = 1'b0;
    rd(8'hFF, "R2 erased value after busy", 1'b0, 1'b0);
  endtask

  task automatic t_erase_busy;
    arr = 8'h00; busy = 1'b1; ers = 1'b1;
    rd(sb(exp_tog, 1'b0, 1'b1), "R8 bit3 high during erase", 1'b1, 1'b0);
    ers = 1'b0;
    rd(sb(exp_tog, 1'b0, 1'b0), "R8 bit3 low during program", 1'b1, 1'b0);
    busy = 1'b0;
  endtask

  task automatic t_fail;
    arr = 8'h5A; busy = 1'b1; ers = 1'b0;
    rd(sb(exp_tog, 1'b0, 1'b0), "R4 error low while ok", 1'b1, 1'b0);
    pulse(fail);
    rd(sb(exp_tog, 1'b1, 1'b0), "R4 error set after fail", 1'b1, 1'b0);
    busy = 1'b0;
    rd(sb(exp_tog, 1'b1, 1'b0), "R4 error held after busy drops", 1'b1, 1'b0);
    rd(sb(exp_tog, 1'b1, 1'b0), "R4 error held again", 1'b1, 1'b0);
    pulse(rcmd);
    rd(8'h5A, "R4 reset command restores read", 1'b0, 1'b0);
  endtask

  task automatic t_window;
    arr = 8'hA5;
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
    pulse(ecmd);
    chk(dq, sb(exp_tog, 1'b0, 1'b0), "R5 bit3 low in window");
    repeat (10) @(negedge clk);
    pulse(ecmd);
    repeat (WCYC - 1) @(negedge clk);
    chk(dq, sb(exp_tog, 1'b0, 1'b0), "R5 window restarted, last cycle");
    chk({7'd0, go}, 8'd0, "R5 no start before expiry");
    @(negedge clk);
    chk({7'd0, go}, 8'd1, "R5 start pulse at expiry");
    chk(dq, 8'hA5, "R5 read after window");
    @(negedge clk);
    chk({7'd0, go}, 8'd0, "R5 start pulse one cycle");
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_prot;
    arr = 8'h96; eprot = 1'b1;
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
    pulse(ecmd);
    eprot = 1'b0;
    chk(dq, sb(exp_tog, 1'b0, 1'b1), "R6 fake busy status");
    repeat (PCYC - 1) @(negedge clk);
    chk(dq, sb(exp_tog, 1'b0, 1'b1), "R6 fake busy last cycle");
    @(negedge clk);
    chk(dq, 8'h96, "R6 read after fake busy");
    chk({7'd0, go}, 8'd0, "R6 no start request");
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_toggle();
    t_erase_busy();
    t_fail();
    t_window();
    t_prot();
    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule